// File: doc/BRIEF.md
# Dual-Clock FIFO with Write-Error and Threshold Flags

This block is a first-in first-out buffer whose two ports run on unrelated clocks. The write side pushes words on its own clock. It reports full, a programmable almost-full threshold and a write-error flag, all in the write clock domain. The read side pops words on a second clock and reports empty and a programmable almost-empty threshold in that domain. Each side keeps a binary pointer with one extra wrap bit. A Gray-coded copy of each pointer crosses to the other domain through a two-stage synchronizer. Storage is a plain register array.

Two read presentations are offered. In the standard presentation a read request pops the head word into an output register. An optional pipeline stage can add one more cycle of latency, in exchange for output timing driven straight from a flop. In the fall-through presentation the head word is fetched ahead into the output register. It is visible, with empty low, before any read request. A read request then discards it and brings the next word forward.

Top module: `xclk_fifo`

## Requirements
- R1: After both resets, empty and almost_empty are 1, and full, almost_full and wr_err are 0.
- R2: Words leave in the order they were accepted. A write offered while full is dropped and leaves the stored words untouched.
- R3: full rises on the write-clock edge that stores the word filling the last free slot. After a read frees a slot, full is still high after the second write-clock edge and low after the third write-clock edge that follows the read edge.
- R4: A write offered while full sets wr_err on that write-clock edge. wr_err stays set while the attempt is held.
- R5: wr_err clears on the first write-clock edge at which wr_en or full was low.
- R6: almost_full is 1 exactly when the number of free slots is at most AF_OFFSET, as seen by the write domain.
- R7: A read request while empty changes neither the read pointer nor rd_data.
- R8: almost_empty is 1 exactly when the number of stored words is at most AE_OFFSET, as seen by the read domain.
- R9: In the standard presentation with the output stage on, the popped word appears on rd_data after the second read-clock edge counted from the edge that samples rd_en. After the first of those edges rd_data still shows the previous word.
- R10: In the fall-through presentation the head word is on rd_data with empty low and no read request. A read request consumes it.
- R11: In the standard presentation, a word written into an empty buffer clears empty on the third read-clock edge after the write edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free slot left |
| almost_full | output | 1 | Free slots at or below AF_OFFSET |
| wr_err | output | 1 | A write was offered while full |
| rd_clk | input | 1 | Read clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Output word |
| empty | output | 1 | No word available |
| almost_empty | output | 1 | Stored words at or below AE_OFFSET |

## Verification
The bench builds two copies with a 9-bit word, a depth of eight and both offsets set to 2. One copy uses the standard presentation with the output stage on. The other uses fall-through, and the two copies share the write stimulus. The small depth lets the bench visit every fill level from empty to full and compare each threshold flag with a count it keeps itself. The write clock has a period of 10 and the read clock a period of 12, and their edges never coincide. This lets the bench count the exact number of edges in the full-release and empty-release paths.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int PMAX = 16;

    typedef enum logic [1:0] {
        RD_PLAIN   = 2'd0,
        RD_PIPED   = 2'd1,
        RD_PREFETCH = 2'd2
    } rd_mode_e;

    typedef struct packed {
        logic full;
        logic almost_full;
        logic err;
    } wr_flags_t;

    typedef struct packed {
        logic empty;
        logic almost_empty;
    } rd_flags_t;

    function automatic logic [PMAX-1:0] to_gray(input logic [PMAX-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PMAX-1:0] from_gray(input logic [PMAX-1:0] g);
        logic [PMAX-1:0] b;
        b[PMAX-1] = g[PMAX-1];
        for (int i = PMAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic rd_mode_e pick_mode(input bit fwft, input bit oreg);
        if (fwft) return RD_PREFETCH;
        if (oreg) return RD_PIPED;
        return RD_PLAIN;
    endfunction

    function automatic bit width_ok(input int w);
        return (w == 4) || (w == 9) || (w == 18) || (w == 36) || (w == 72);
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter logic [12:0] AF_OFFSET = 13'h2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [ADDR_W:0] rq_gray,
    output logic [ADDR_W-1:0] waddr,
    output logic            we,
    output logic [ADDR_W:0] wptr_gray,
    output wr_flags_t       flags
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PW-1:0] wbin, wbin_nx, rbin, used_nx;
    wr_flags_t     fl_q;
    logic          push;
    int            free_nx;

    assign push    = wr_en && !fl_q.full;
    assign wbin_nx = wbin + PW'(push);
    assign rbin    = PW'(from_gray(PMAX'(rq_gray)));
    assign used_nx = wbin_nx - rbin;
    assign free_nx = DEPTH - int'(used_nx);

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin      <= '0;
            wptr_gray <= '0;
            fl_q      <= '{full: 1'b0, almost_full: 1'b0, err: 1'b0};
        end else begin
            wbin           <= wbin_nx;
            wptr_gray      <= PW'(to_gray(PMAX'(wbin_nx)));
            fl_q.full      <= (int'(used_nx) == DEPTH);
            fl_q.almost_full <= (free_nx <= int'(AF_OFFSET));
            fl_q.err       <= wr_en && fl_q.full;
        end
    end

    assign we    = push;
    assign waddr = wbin[ADDR_W-1:0];
    assign flags = fl_q;
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter int          DATA_W    = 9,
    parameter logic [12:0] AE_OFFSET = 13'h2,
    parameter bit          FWFT      = 1'b0,
    parameter bit          OUT_REG   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wq_gray,
    input  logic [DATA_W-1:0] mem_q,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rptr_gray,
    output logic [DATA_W-1:0] rd_data,
    output rd_flags_t         flags
);
    localparam int       PW   = ADDR_W + 1;
    localparam rd_mode_e MODE = pick_mode(FWFT, OUT_REG);

    logic [PW-1:0]     rbin, rbin_nx, wbin, stored_nx;
    logic              mem_empty, ov, ov_nx, want, pop, ae_q;
    logic [DATA_W-1:0] hold;

    assign want      = (MODE == RD_PREFETCH) ? (!ov || rd_en) : rd_en;
    assign pop       = want && !mem_empty;
    assign ov_nx     = (MODE == RD_PREFETCH) ? (pop ? 1'b1 : (rd_en ? 1'b0 : ov)) : 1'b0;
    assign rbin_nx   = rbin + PW'(pop);
    assign wbin      = PW'(from_gray(PMAX'(wq_gray)));
    assign stored_nx = wbin - rbin_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin      <= '0;
            rptr_gray <= '0;
            mem_empty <= 1'b1;
            ov        <= 1'b0;
            ae_q      <= 1'b1;
            hold      <= '0;
        end else begin
            rbin      <= rbin_nx;
            rptr_gray <= PW'(to_gray(PMAX'(rbin_nx)));
            mem_empty <= (stored_nx == '0);
            ov        <= ov_nx;
            ae_q      <= (int'(stored_nx) + int'(ov_nx)) <= int'(AE_OFFSET);
            if (pop) hold <= mem_q;
        end
    end

    assign raddr = rbin[ADDR_W-1:0];

    generate
        if (MODE == RD_PIPED) begin : g_piped
            logic [DATA_W-1:0] pipe;
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= hold;
            end
            assign rd_data = pipe;
        end else begin : g_direct
            assign rd_data = hold;
        end
    endgenerate

    assign flags.empty        = (MODE == RD_PREFETCH) ? !ov : mem_empty;
    assign flags.almost_empty = ae_q;
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
    import dcf_pkg::*;
#(
    parameter int          DATA_W    = 9,
    parameter int          ADDR_W    = 4,
    parameter logic [12:0] AF_OFFSET = 13'h2,
    parameter logic [12:0] AE_OFFSET = 13'h2,
    parameter bit          FWFT      = 1'b0,
    parameter bit          OUT_REG   = 1'b1
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              almost_full,
    output logic              wr_err,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              almost_empty
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] mem_q;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PW-1:0]     wptr_gray, rptr_gray, wq_gray, rq_gray;
    logic              we;
    wr_flags_t         wfl;
    rd_flags_t         rfl;

    dcf_wr_side #(.ADDR_W(ADDR_W), .AF_OFFSET(AF_OFFSET)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .wr_en(wr_en), .rq_gray(rq_gray),
        .waddr(waddr), .we(we), .wptr_gray(wptr_gray), .flags(wfl)
    );

    dcf_sync #(.W(PW), .STAGES(2)) u_rq_sync (
        .clk(wr_clk), .rst(wr_rst), .d(rptr_gray), .q(rq_gray)
    );

    dcf_sync #(.W(PW), .STAGES(2)) u_wq_sync (
        .clk(rd_clk), .rst(rd_rst), .d(wptr_gray), .q(wq_gray)
    );

    always_ff @(posedge wr_clk) begin
        if (we) store[waddr] <= wr_data;
    end

    assign mem_q = store[raddr];

    dcf_rd_side #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AE_OFFSET(AE_OFFSET),
        .FWFT(FWFT), .OUT_REG(OUT_REG)
    ) u_rd (
        .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en), .wq_gray(wq_gray),
        .mem_q(mem_q), .raddr(raddr), .rptr_gray(rptr_gray),
        .rd_data(rd_data), .flags(rfl)
    );

    assign full         = wfl.full;
    assign almost_full  = wfl.almost_full;
    assign wr_err       = wfl.err;
    assign empty        = rfl.empty;
    assign almost_empty = rfl.almost_empty;
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk
    import dcf_pkg::*;
#(
    parameter int PW   = 5,
    parameter int DW   = 9,
    parameter bit FWFT = 1'b0
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          wr_en,
    input logic          full,
    input logic          almost_full,
    input logic          wr_err,
    input logic [PW-1:0] wptr_gray,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          rd_en,
    input logic          empty,
    input logic          almost_empty,
    input logic [PW-1:0] rptr_gray
);
    initial begin
        a_width_legal: assert (width_ok(DW))
            else $error("data width %0d not supported", DW);
    end

    // R2: a write offered while full leaves the write pointer alone
    p_ptr_hold_r2: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (full && wr_en) |=> $stable(wptr_gray));

    // R2: the crossing pointer moves by at most one bit per edge
    p_gray_step_r2: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

    // R4
    p_err_raise_r4: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (full && wr_en) |=> wr_err);

    // R5
    p_err_drop_r5: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (!wr_en || !full) |=> !wr_err);

    // R6: zero free slots is within any threshold
    p_af_cover_r6: assert property (@(posedge wr_clk) disable iff (wr_rst)
        full |-> almost_full);

    // R7
    p_no_pop_empty_r7: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (!FWFT && empty && rd_en) |=> $stable(rptr_gray));

    // R8
    p_ae_cover_r8: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (!FWFT && empty) |-> almost_empty);
endmodule

bind xclk_fifo xclk_fifo_chk #(.PW(ADDR_W + 1), .DW(DATA_W), .FWFT(FWFT)) u_chk (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .full(full),
    .almost_full(almost_full), .wr_err(wr_err), .wptr_gray(wptr_gray),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .empty(empty),
    .almost_empty(almost_empty), .rptr_gray(rptr_gray)
);

// File: tb/xclk_fifo_bench.sv
`timescale 1ns/100ps
module xclk_fifo_bench;
    localparam int WR_PER = 10;
    localparam int RD_PER = 12;
    localparam int DW     = 9;
    localparam int DEPTH  = 8;
    localparam int AF     = 2;
    localparam int AE     = 2;

    logic wr_clk = 1'b0, rd_clk = 1'b0;
    logic wr_rst = 1'b1, rd_rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0, rd_en_f = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data, rd_data_f;
    logic full, almost_full, wr_err, empty, almost_empty;
    logic full_f, almost_full_f, wr_err_f, empty_f, almost_empty_f;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(WR_PER/2) wr_clk = ~wr_clk;
    always #(RD_PER/2) rd_clk = ~rd_clk;

    xclk_fifo #(.DATA_W(DW), .ADDR_W(3), .AF_OFFSET(13'h2), .AE_OFFSET(13'h2),
                .FWFT(1'b0), .OUT_REG(1'b1)) u_xclk_fifo (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .almost_full(almost_full), .wr_err(wr_err),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data),
        .empty(empty), .almost_empty(almost_empty)
    );

    xclk_fifo #(.DATA_W(DW), .ADDR_W(3), .AF_OFFSET(13'h2), .AE_OFFSET(13'h2),
                .FWFT(1'b1), .OUT_REG(1'b1)) u_xclk_fifo_fwft (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .full(full_f), .almost_full(almost_full_f), .wr_err(wr_err_f),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en_f), .rd_data(rd_data_f),
        .empty(empty_f), .almost_empty(almost_empty_f)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic std_read(input logic [DW-1:0] prev, input logic [DW-1:0] want, input int left);
        @(posedge rd_clk); rd_en <= 1'b1;
        @(posedge rd_clk); rd_en <= 1'b0;
        #1;
        chk(rd_data == prev, "R9 data not yet through stage", int'(rd_data), int'(prev));
        chk(almost_empty == (left <= AE), "R8 almost_empty while draining",
            int'(almost_empty), int'(left <= AE));
        @(posedge rd_clk); #1;
        chk(rd_data == want, "R2 R9 order and latency", int'(rd_data), int'(want));
    endtask

    initial begin
        repeat (4) @(posedge wr_clk);
        wr_rst <= 1'b0;
    end

    initial begin
        repeat (4) @(posedge rd_clk);
        rd_rst <= 1'b0;
    end

    initial begin
        repeat (6) @(posedge rd_clk);
        #1;
        // R1 reset state
        chk(empty == 1'b1, "R1 empty", int'(empty), 1);
        chk(almost_empty == 1'b1, "R1 almost_empty", int'(almost_empty), 1);
        chk(full == 1'b0, "R1 full", int'(full), 0);
        chk(almost_full == 1'b0, "R1 almost_full", int'(almost_full), 0);
        chk(wr_err == 1'b0, "R1 wr_err", int'(wr_err), 0);
        chk(empty_f == 1'b1, "R1 empty fall-through copy", int'(empty_f), 1);

        // R7: read requests while empty
        @(posedge rd_clk); rd_en <= 1'b1; rd_en_f <= 1'b1;
        repeat (2) @(posedge rd_clk);
        rd_en <= 1'b0; rd_en_f <= 1'b0;
        repeat (2) @(posedge rd_clk);
        #1;
        chk(rd_data == '0, "R7 rd_data after read on empty", int'(rd_data), 0);
        chk(empty == 1'b1, "R7 still empty", int'(empty), 1);

        // R11: empty release counted in read edges
        @(posedge wr_clk); wr_en <= 1'b1; wr_data <= 9'h100;
        @(posedge wr_clk); wr_en <= 1'b0;
        for (int k = 1; k <= 3; k++) begin
            @(posedge rd_clk); #1;
            chk(empty == (k < 3), "R11 empty release edge", int'(empty), int'(k < 3));
        end

        // R10: fall-through copy shows the word with no request
        repeat (3) @(posedge rd_clk);
        #1;
        chk(empty_f == 1'b0, "R10 fall-through empty low", int'(empty_f), 0);
        chk(rd_data_f == 9'h100, "R10 fall-through head word", int'(rd_data_f), 'h100);

        // R9 / R7: first word out of the standard copy is the one written
        std_read(9'h000, 9'h100, 0);

        @(posedge rd_clk); rd_en_f <= 1'b1;
        @(posedge rd_clk); rd_en_f <= 1'b0;
        repeat (2) @(posedge rd_clk);
        #1;
        chk(empty_f == 1'b1, "R10 request consumes head", int'(empty_f), 1);
        repeat (8) @(posedge wr_clk);

        // R3 / R6: fill sweep
        @(posedge wr_clk); #1;
        for (int i = 1; i <= DEPTH; i++) begin
            wr_en = 1'b1;
            wr_data = 9'h0A0 + 9'(i);
            @(posedge wr_clk); #1;
            chk(almost_full == ((DEPTH - i) <= AF), "R6 almost_full at fill level",
                int'(almost_full), int'((DEPTH - i) <= AF));
            chk(full == (i == DEPTH), "R3 full at fill level", int'(full), int'(i == DEPTH));
        end

        // R4 / R5: write attempts while full
        wr_data = 9'h1FF;
        @(posedge wr_clk); #1;
        chk(wr_err == 1'b1, "R4 wr_err raised", int'(wr_err), 1);
        @(posedge wr_clk); #1;
        chk(wr_err == 1'b1, "R4 wr_err held", int'(wr_err), 1);
        chk(full == 1'b1, "R3 still full", int'(full), 1);
        wr_en = 1'b0;
        @(posedge wr_clk); #1;
        chk(wr_err == 1'b0, "R5 wr_err cleared", int'(wr_err), 0);

        repeat (6) @(posedge rd_clk);
        #1;
        chk(almost_empty == 1'b0, "R8 almost_empty when full", int'(almost_empty), 0);

        // R3: full release counted in write edges
        @(posedge rd_clk); rd_en <= 1'b1;
        @(posedge rd_clk); rd_en <= 1'b0;
        for (int k = 1; k <= 3; k++) begin
            @(posedge wr_clk); #1;
            chk(full == (k < 3), "R3 full release edge", int'(full), int'(k < 3));
        end
        repeat (2) @(posedge rd_clk);
        #1;
        chk(rd_data == 9'h0A1, "R2 first word of fill", int'(rd_data), 'h0A1);

        // R2 / R8 / R9: drain the rest
        for (int i = 2; i <= DEPTH; i++) begin
            std_read(9'h0A0 + 9'(i - 1), 9'h0A0 + 9'(i), DEPTH - i);
        end
        chk(empty == 1'b1, "R2 dropped write never appears", int'(empty), 1);

        // R7: request on empty after drain
        @(posedge rd_clk); rd_en <= 1'b1;
        repeat (2) @(posedge rd_clk);
        rd_en <= 1'b0;
        repeat (2) @(posedge rd_clk);
        #1;
        chk(rd_data == 9'h0A8, "R7 rd_data held on empty read", int'(rd_data), 'h0A8);

        // R10: fall-through copy drains in order without a fetch cycle
        for (int i = 1; i <= DEPTH; i++) begin
            #1;
            chk(rd_data_f == 9'h0A0 + 9'(i), "R10 fall-through order",
                int'(rd_data_f), int'(9'h0A0 + 9'(i)));
            @(posedge rd_clk); rd_en_f <= 1'b1;
            @(posedge rd_clk); rd_en_f <= 1'b0;
            repeat (4) @(posedge rd_clk);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(WR_PER * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule